// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between the agents that issue stores (the core and its two data caches, arbitrated outside the block onto one store port) and the bus controller. It holds byte-masked stores in eight 16-byte line entries until the memory write port accepts them. Entries leave through a valid/ready port in the order they were allocated.

Merging is controlled by two inputs together: a global coalescing enable and a per-store attribute saying the target region may be coalesced. When both are set, a store may merge into any buffered entry for the same 16-byte line, except the entry currently offered to memory. A merge writes the new bytes into an older entry, so the new data can reach memory ahead of stores that were issued before it. When either input is clear, every store gets its own entry and memory sees the stores in the order they were issued.

A store to an uncached, unbuffered region takes its own entry and stalls the requester until that entry has been handed to memory. A drain request closes the store port, empties the buffer and then pulses a done flag.

Top module: `wb_coalesce_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_valid_o`=0, `stall_o`=0, `drain_done_o`=0 and `st_ready_o`=1. A store is taken on a clock edge where both `st_valid_i` and `st_ready_o` are high.
- R2: With `coal_en_i`=0, each accepted store makes its own entry, even when `st_merge_ok_i`=1 and the line matches. Memory writes then appear in the order the stores were accepted, and each write carries that store's line, byte enables and bytes.
- R3: With `coal_en_i`=1 and `st_merge_ok_i`=0, stores never merge. Each store makes its own entry and the stores leave in order.
- R4: With `coal_en_i`=1, `st_merge_ok_i`=1 and `st_uncached_i`=0, a store whose line matches a buffered entry other than the one at the memory port merges into the lowest-numbered such entry. The entry's byte enables become the OR of the old and new enables. Enabled bytes take the new data and all other bytes keep the old data. No entry is added, so a later store can reach memory before earlier ones.
- R5: The entry currently offered on the memory port is never a merge target. A matching store allocates a new entry instead.
- R6: When all eight entries are occupied and the store cannot merge, `st_ready_o` is 0. A store that can merge is still accepted while the buffer is full.
- R7: A store with `st_uncached_i`=1 never merges and always allocates an entry. `stall_o` rises in the cycle after it is accepted and stays high until the clock edge on which that entry completes its memory handshake. `st_ready_o` is 0 while `stall_o` is 1.
- R8: While `mem_valid_o`=1 and `mem_ready_i`=0, the next cycle still has `mem_valid_o`=1 and unchanged `mem_blk_o`, `mem_be_o` and `mem_data_o`.
- R9: A one-cycle `drain_req_i` pulse makes `st_ready_o` 0 from the next cycle onward. All entries are written to memory. `drain_done_o` then pulses for one cycle, in the cycle after the buffer became empty, and `st_ready_o` returns at the same time as the pulse. If the buffer is already empty, the pulse comes two cycles after the request edge.
- R10: On `mem_data_o`, byte b occupies bits [8b+7:8b] and is enabled by `mem_be_o[b]`. Bytes whose enable bit is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coal_en_i | input | 1 | Global coalescing enable |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store port can take the presented store |
| st_blk_i | input | 28 | Store line address (byte address bits above the 16-byte offset) |
| st_be_i | input | 16 | Store byte enables, bit b for byte b |
| st_data_i | input | 128 | Store data, byte b in bits [8b+7:8b] |
| st_merge_ok_i | input | 1 | Region attribute allowing coalescing |
| st_uncached_i | input | 1 | Store targets an uncached, unbuffered region |
| stall_o | output | 1 | Requester stalled on an uncached store in flight |
| drain_req_i | input | 1 | Pulse requesting the buffer be emptied |
| drain_done_o | output | 1 | One-cycle pulse when the drain has finished |
| mem_valid_o | output | 1 | Memory write valid |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_blk_o | output | 28 | Memory write line address |
| mem_be_o | output | 16 | Memory write byte enables |
| mem_data_o | output | 128 | Memory write data |

## Verification
The bench runs the same five-store sequence, which alternates between two lines, under all four settings of the global enable and the region attribute, and compares every memory write with an arithmetic model. A buffer that merged when either control bit was clear would emit too few writes. A buffer that merged into the entry on the memory port would emit two writes instead of three, and its first write would carry bytes it should not have. The bench also fills all eight entries to check that a full buffer blocks new stores but still accepts a merge. It times the stall of an uncached store against the exact handshake edge, since a stall released early or late would let a store through at the wrong moment. It checks the drain-done cycle for both an empty and a loaded buffer, where an off-by-one in the drain sequencing would show up.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    WB_RUN   = 2'd0,
    WB_DRAIN = 2'd1,
    WB_DONE  = 2'd2
  } wb_drain_e;
endpackage

// File: rtl/wb_match.sv
module wb_match #(
  parameter int DEPTH = 8,
  parameter int BLK_W = 28,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0]            key_i,
  input  logic                        excl_en_i,
  input  logic [IDX_W-1:0]            excl_idx_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [DEPTH-1:0] cand;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign cand[i] = valid_i[i] && (blk_i[i] == key_i) &&
                     !(excl_en_i && (excl_idx_i == IDX_W'(i)));
  end

  always_comb begin
    hit_o = |cand;
    idx_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/wb_entries.sv
module wb_entries #(
  parameter int DEPTH = 8,
  parameter int BLK_W = 28,
  parameter int NB    = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DW    = 8 * NB
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [IDX_W-1:0]            alloc_idx,
  input  logic                        merge_en,
  input  logic [IDX_W-1:0]            merge_idx,
  input  logic                        pop_en,
  input  logic [IDX_W-1:0]            pop_idx,
  input  logic [BLK_W-1:0]            wr_blk,
  input  logic [NB-1:0]               wr_be,
  input  logic [DW-1:0]               wr_data,
  output logic [DEPTH-1:0]            valid_o,
  output logic [DEPTH-1:0][BLK_W-1:0] blk_o,
  output logic [DEPTH-1:0][NB-1:0]    be_o,
  output logic [DEPTH-1:0][DW-1:0]    data_o
);
  logic [DW-1:0] wmask;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wmask[8*b +: 8] = {8{wr_be[b]}};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             v_q, v_d;
    logic [BLK_W-1:0] b_q, b_d;
    logic [NB-1:0]    e_q, e_d;
    logic [DW-1:0]    d_q, d_d;
    logic             is_alloc, is_merge, is_pop, upd;

    always_comb begin
      is_alloc = alloc_en && (alloc_idx == IDX_W'(i));
      is_merge = merge_en && (merge_idx == IDX_W'(i));
      is_pop   = pop_en   && (pop_idx   == IDX_W'(i));
      upd      = is_alloc || is_merge;
      v_d      = (v_q && !is_pop) || is_alloc;
      if (is_alloc) begin
        b_d = wr_blk;
        e_d = wr_be;
        d_d = wr_data & wmask;
      end else begin
        b_d = b_q;
        e_d = e_q | wr_be;
        d_d = (d_q & ~wmask) | (wr_data & wmask);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= '0;
        e_q <= '0;
        d_q <= '0;
      end else begin
        v_q <= v_d;
        if (upd) begin
          b_q <= b_d;
          e_q <= e_d;
          d_q <= d_d;
        end
      end
    end

    assign valid_o[i] = v_q;
    assign blk_o[i]   = b_q;
    assign be_o[i]    = e_q;
    assign data_o[i]  = d_q;
  end

  AST_MERGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |-> valid_o[merge_idx]); // R4
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !valid_o[alloc_idx]); // R6
  AST_NO_MERGE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(merge_en && pop_en && (merge_idx == pop_idx))); // R5
endmodule

// File: rtl/wb_coalesce_buffer.sv
module wb_coalesce_buffer
  import wb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK_W = 28,
  parameter int NB    = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int DW    = 8 * NB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coal_en_i,
  input  logic             st_valid_i,
  output logic             st_ready_o,
  input  logic [BLK_W-1:0] st_blk_i,
  input  logic [NB-1:0]    st_be_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic             st_merge_ok_i,
  input  logic             st_uncached_i,
  output logic             stall_o,
  input  logic             drain_req_i,
  output logic             drain_done_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [BLK_W-1:0] mem_blk_o,
  output logic [NB-1:0]    mem_be_o,
  output logic [DW-1:0]    mem_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d, sidx_q, sidx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stall_q, stall_d;
  wb_drain_e        dstate_q, dstate_d;

  logic [DEPTH-1:0]            ent_valid;
  logic [DEPTH-1:0][BLK_W-1:0] ent_blk;
  logic [DEPTH-1:0][NB-1:0]    ent_be;
  logic [DEPTH-1:0][DW-1:0]    ent_data;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             merge_allow, can_merge, full, accept, alloc_en, merge_en, pop_en;

  wb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .valid_i    (ent_valid),
    .blk_i      (ent_blk),
    .key_i      (st_blk_i),
    .excl_en_i  (mem_valid_o),
    .excl_idx_i (head_q),
    .hit_o      (hit),
    .idx_o      (hit_idx)
  );

  wb_entries #(.DEPTH(DEPTH), .BLK_W(BLK_W), .NB(NB)) u_entries (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .alloc_en  (alloc_en),
    .alloc_idx (tail_q),
    .merge_en  (merge_en),
    .merge_idx (hit_idx),
    .pop_en    (pop_en),
    .pop_idx   (head_q),
    .wr_blk    (st_blk_i),
    .wr_be     (st_be_i),
    .wr_data   (st_data_i),
    .valid_o   (ent_valid),
    .blk_o     (ent_blk),
    .be_o      (ent_be),
    .data_o    (ent_data)
  );

  always_comb begin
    merge_allow = coal_en_i && st_merge_ok_i && !st_uncached_i;
    can_merge   = merge_allow && hit;
    full        = (cnt_q == CNT_W'(DEPTH));
    st_ready_o  = !stall_q && (dstate_q != WB_DRAIN) && (can_merge || !full);
    accept      = st_valid_i && st_ready_o;
    merge_en    = accept && can_merge;
    alloc_en    = accept && !can_merge;
    mem_valid_o = (cnt_q != '0);
    pop_en      = mem_valid_o && mem_ready_i;
    mem_blk_o   = ent_blk[head_q];
    mem_be_o    = ent_be[head_q];
    mem_data_o  = ent_data[head_q];
    stall_o     = stall_q;
    drain_done_o = (dstate_q == WB_DONE);
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (pop_en)   head_d = (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    if (alloc_en) tail_d = (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    cnt_d = cnt_q + CNT_W'(alloc_en) - CNT_W'(pop_en);

    stall_d = stall_q;
    sidx_d  = sidx_q;
    if (alloc_en && st_uncached_i) begin
      stall_d = 1'b1;
      sidx_d  = tail_q;
    end else if (stall_q && pop_en && (head_q == sidx_q)) begin
      stall_d = 1'b0;
    end

    dstate_d = dstate_q;
    case (dstate_q)
      WB_RUN:   if (drain_req_i) dstate_d = WB_DRAIN;
      WB_DRAIN: if (cnt_q == '0) dstate_d = WB_DONE;
      default:  dstate_d = WB_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      stall_q  <= 1'b0;
      sidx_q   <= '0;
      dstate_q <= WB_RUN;
    end else begin
      head_q   <= head_d;
      tail_q   <= tail_d;
      cnt_q    <= cnt_d;
      stall_q  <= stall_d;
      sidx_q   <= sidx_d;
      dstate_q <= dstate_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnt_q <= CNT_W'(DEPTH)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_blk_o) &&
      $stable(mem_be_o) && $stable(mem_data_o))); // R8
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stall_o) |-> $past(st_valid_i && st_uncached_i)); // R7
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_int_n)
    drain_done_o |-> !mem_valid_o); // R9
endmodule

// File: tb/wb_coalesce_buffer_tb.sv
module wb_coalesce_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         coal_en_i, st_valid_i, st_merge_ok_i, st_uncached_i;
  logic         drain_req_i, mem_ready_i;
  logic [27:0]  st_blk_i;
  logic [15:0]  st_be_i;
  logic [127:0] st_data_i;
  logic         st_ready_o, stall_o, drain_done_o, mem_valid_o;
  logic [27:0]  mem_blk_o;
  logic [15:0]  mem_be_o;
  logic [127:0] mem_data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [27:0]  q_blk [0:15];
  logic [15:0]  q_be  [0:15];
  logic [127:0] q_dat [0:15];
  int q_n = 0;

  always #5 clk = ~clk;

  wb_coalesce_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .coal_en_i(coal_en_i),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_blk_i(st_blk_i),
    .st_be_i(st_be_i), .st_data_i(st_data_i), .st_merge_ok_i(st_merge_ok_i),
    .st_uncached_i(st_uncached_i), .stall_o(stall_o), .drain_req_i(drain_req_i),
    .drain_done_o(drain_done_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_blk_o(mem_blk_o), .mem_be_o(mem_be_o), .mem_data_o(mem_data_o)
  );

  function automatic logic [127:0] bmask(logic [15:0] be);
    logic [127:0] m;
    for (int b = 0; b < 16; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [127:0] mkdata(int s);
    return {4{(32'(s) * 32'h0101_0101) ^ 32'h5A3C_9617}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic push(input logic [27:0] blk, input logic [15:0] be, input logic [127:0] dat,
                      input bit ok, input bit unc, output bit acc);
    bit merged;
    @(negedge clk);
    st_valid_i = 1'b1; st_blk_i = blk; st_be_i = be; st_data_i = dat;
    st_merge_ok_i = ok; st_uncached_i = unc;
    #1 acc = st_ready_o;
    @(posedge clk);
    #1 st_valid_i = 1'b0;
    if (acc) begin
      merged = 1'b0;
      if (coal_en_i && ok && !unc) begin
        for (int j = 1; j < q_n; j++) begin
          if (!merged && q_blk[j] == blk) begin
            q_be[j]  = q_be[j] | be;
            q_dat[j] = (q_dat[j] & ~bmask(be)) | (dat & bmask(be));
            merged = 1'b1;
          end
        end
      end
      if (!merged) begin
        q_blk[q_n] = blk; q_be[q_n] = be; q_dat[q_n] = dat & bmask(be);
        q_n++;
      end
    end
  endtask

  task automatic pop_check(input string tag);
    @(negedge clk);
    mem_ready_i = 1'b1;
    #1;
    chk(mem_valid_o == 1'b1, tag, 128'(mem_valid_o), 128'd1);
    chk(mem_blk_o == q_blk[0], tag, 128'(mem_blk_o), 128'(q_blk[0]));
    chk(mem_be_o == q_be[0], tag, 128'(mem_be_o), 128'(q_be[0]));
    chk(mem_data_o == q_dat[0], tag, mem_data_o, q_dat[0]);
    @(posedge clk);
    #1 mem_ready_i = 1'b0;
    for (int j = 0; j < q_n - 1; j++) begin
      q_blk[j] = q_blk[j+1]; q_be[j] = q_be[j+1]; q_dat[j] = q_dat[j+1];
    end
    q_n--;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit acc;
    string tag;
    logic [15:0] bes [0:4];
    bes[0] = 16'h00FF; bes[1] = 16'h0F0F; bes[2] = 16'hFF00; bes[3] = 16'h3C3C; bes[4] = 16'h0001;
    rst_n = 1'b0; coal_en_i = 1'b0; st_valid_i = 1'b0; st_merge_ok_i = 1'b0;
    st_uncached_i = 1'b0; drain_req_i = 1'b0; mem_ready_i = 1'b0;
    st_blk_i = '0; st_be_i = '0; st_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_valid_o == 1'b0, "R1 reset valid", 128'(mem_valid_o), 128'd0);
    chk(st_ready_o == 1'b1, "R1 reset ready", 128'(st_ready_o), 128'd1);
    chk(stall_o == 1'b0, "R1 reset stall", 128'(stall_o), 128'd0);
    chk(drain_done_o == 1'b0, "R1 reset done", 128'(drain_done_o), 128'd0);

    // R2 R3 R4 R5: same sequence under every control combination
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 2; m++) begin
        coal_en_i = c[0];
        tag = (c == 0) ? "R2" : ((m == 0) ? "R3" : "R4");
        for (int k = 0; k < 5; k++) begin
          push((k % 2 == 0) ? 28'h40 : 28'h41, bes[k], mkdata(k + 10 * c + 20 * m), m[0], 1'b0, acc);
          chk(acc, "R1 accept", 128'(acc), 128'd1);
        end
        while (q_n > 0) pop_check(tag);
        @(negedge clk);
        chk(mem_valid_o == 1'b0, (c == 1 && m == 1) ? "R5" : tag, 128'(mem_valid_o), 128'd0);
      end
    end

    // R6 R10: fill with eight single-byte stores
    coal_en_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      push(28'h100 + 28'(i), 16'h1 << i, {128{1'b1}}, 1'b1, 1'b0, acc);
      chk(acc, "R6 fill", 128'(acc), 128'd1);
    end
    push(28'h200, 16'hFFFF, mkdata(7), 1'b1, 1'b0, acc);
    chk(!acc, "R6 full blocks", 128'(acc), 128'd0);
    coal_en_i = 1'b1;
    push(28'h200, 16'hFFFF, mkdata(7), 1'b1, 1'b0, acc);
    chk(!acc, "R6 full no match", 128'(acc), 128'd0);
    push(28'h103, 16'h8000, mkdata(9), 1'b0, 1'b0, acc);
    chk(!acc, "R6 full attr off", 128'(acc), 128'd0);
    push(28'h103, 16'h8000, mkdata(9), 1'b1, 1'b0, acc);
    chk(acc, "R6 full merge", 128'(acc), 128'd1);
    @(negedge clk);
    chk(mem_data_o == 128'hFF, "R10 zero bytes", mem_data_o, 128'hFF);
    while (q_n > 0) pop_check("R6 R10");

    // R7 R8: uncached store
    push(28'h300, 16'h000F, mkdata(30), 1'b1, 1'b0, acc);
    push(28'h301, 16'h00F0, mkdata(31), 1'b1, 1'b0, acc);
    push(28'h301, 16'h0F00, mkdata(32), 1'b1, 1'b1, acc);
    chk(acc, "R7 uncached accept", 128'(acc), 128'd1);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      st_valid_i = 1'b1; st_blk_i = 28'h300; st_merge_ok_i = 1'b1; st_uncached_i = 1'b0;
      #1;
      chk(stall_o == 1'b1, "R7 stall high", 128'(stall_o), 128'd1);
      chk(st_ready_o == 1'b0, "R7 ready low", 128'(st_ready_o), 128'd0);
      chk(mem_valid_o && mem_blk_o == 28'h300, "R8 hold", 128'(mem_blk_o), 128'h300);
      #1 st_valid_i = 1'b0;
    end
    pop_check("R7");
    pop_check("R7");
    @(negedge clk);
    chk(stall_o == 1'b1, "R7 stall before handshake", 128'(stall_o), 128'd1);
    pop_check("R7");
    @(negedge clk);
    chk(stall_o == 1'b0, "R7 stall released", 128'(stall_o), 128'd0);
    chk(st_ready_o == 1'b1, "R7 ready back", 128'(st_ready_o), 128'd1);

    // R9: drain of a loaded buffer
    coal_en_i = 1'b0;
    for (int k = 0; k < 3; k++) push(28'h400 + 28'(k), 16'hF0F0, mkdata(40 + k), 1'b0, 1'b0, acc);
    @(negedge clk);
    drain_req_i = 1'b1;
    @(posedge clk);
    #1 drain_req_i = 1'b0;
    @(negedge clk);
    chk(st_ready_o == 1'b0, "R9 port closed", 128'(st_ready_o), 128'd0);
    chk(drain_done_o == 1'b0, "R9 not done", 128'(drain_done_o), 128'd0);
    while (q_n > 0) pop_check("R9");
    @(negedge clk);
    chk(drain_done_o == 1'b0, "R9 done late by one", 128'(drain_done_o), 128'd0);
    chk(st_ready_o == 1'b0, "R9 still closed", 128'(st_ready_o), 128'd0);
    @(negedge clk);
    chk(drain_done_o == 1'b1, "R9 done pulse", 128'(drain_done_o), 128'd1);
    chk(st_ready_o == 1'b1, "R9 reopened", 128'(st_ready_o), 128'd1);
    @(negedge clk);
    chk(drain_done_o == 1'b0, "R9 pulse width", 128'(drain_done_o), 128'd0);

    // R9: drain of an empty buffer
    @(negedge clk);
    drain_req_i = 1'b1;
    @(posedge clk);
    #1 drain_req_i = 1'b0;
    @(negedge clk);
    chk(drain_done_o == 1'b0, "R9 empty first", 128'(drain_done_o), 128'd0);
    @(negedge clk);
    chk(drain_done_o == 1'b1, "R9 empty done", 128'(drain_done_o), 128'd1);
    @(negedge clk);
    chk(drain_done_o == 1'b0, "R9 empty clear", 128'(drain_done_o), 128'd0);

    finish_up();
  end
endmodule